// File: doc/BRIEF.md
# Pipeline Forwarding and Stall Unit

This block sits beside the decode stage of a five-stage in-order integer pipeline: fetch, decode with register read, ALU, memory, writeback. Inter-stage buffers carry each instruction and its control bits forward. Each cycle the block looks at the source registers of the instruction now in decode. It compares them with the destinations of the three older instructions in the ALU, memory and writeback stages. It then produces the control values that travel with the decoded instruction into the decode-to-ALU buffer.

There are three kinds of output. The first kind is the two ALU operand selects. Operand A picks the register value, PC+4 or the result Z, which comes from the ALU-to-memory buffer. Operand B picks the register value, the immediate offset or Z. The second kind is two bypass selects for the register-read stage. These replace a register-file read with the value leaving the memory stage or with the value being written back. The third kind is a stall. When the ALU stage holds a load whose destination the decode instruction reads, the block holds the PC and the fetch-to-decode buffer, and it places a no-op bubble into the decode-to-ALU buffer for exactly one cycle.

All outputs are combinational from the current stage contents, so a stall takes effect in the cycle it is detected. The clock and reset inputs serve only the built-in checks.

Top module: `fwd_stall_unit`

## Requirements
- R1: `alu_a_sel` is 1 (PC+4) when `id_a_is_pc` is set. Otherwise it is 2 (Z) when the ALU-stage instruction is a non-load that writes the register that operand A reads. Otherwise it is 0 (register). Code 3 never appears.
- R2: `alu_b_sel` is 1 (immediate) when `id_b_is_imm` is set. Otherwise it is 2 (Z) when the ALU-stage instruction is a non-load that writes the register that operand B reads. Otherwise it is 0 (register). Code 3 never appears.
- R3: Each bypass select (`byp_a_sel`, `byp_b_sel`) is 1 when the memory-stage instruction writes that source register, and 2 when only the writeback-stage instruction writes it. Otherwise it is 0 (register file). Code 3 never appears.
- R4: When more than one older instruction writes the same source register, the newest one wins. The memory stage beats the writeback stage for bypass, and an ALU-stage match gives Z on the ALU select.
- R5: A load in the ALU stage, with write enable set, whose destination equals a source register that decode uses, raises `pc_hold`, `fd_hold` and `de_bubble` in that same cycle. A load with a different destination raises none of them.
- R6: In the cycle after a load-use stall, the load has moved to the memory stage and the ALU stage holds the bubble. In that cycle no stall is raised and the bypass select for the matching source is 1. So a load-use case costs exactly one bubble.
- R7: Register number 0 never causes forwarding, bypass or a stall.
- R8: A stage whose write enable is clear, or a source whose use flag (`id_use_rs1`/`id_use_rs2`) is clear, causes no forwarding, no bypass and no stall for that source.
- R9: `pc_hold`, `fd_hold` and `de_bubble` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the built-in checks |
| rst_n | input | 1 | Active-low reset for the built-in checks |
| id_rs1 | input | REG_W | Source register of operand A in decode |
| id_rs2 | input | REG_W | Source register of operand B in decode |
| id_use_rs1 | input | 1 | Decode instruction reads `id_rs1` |
| id_use_rs2 | input | 1 | Decode instruction reads `id_rs2` |
| id_a_is_pc | input | 1 | Operand A takes PC+4 |
| id_b_is_imm | input | 1 | Operand B takes the immediate offset |
| ex_rd | input | REG_W | Destination of the ALU-stage instruction |
| ex_we | input | 1 | ALU-stage instruction writes a register |
| ex_is_load | input | 1 | ALU-stage instruction is a load |
| mem_rd | input | REG_W | Destination of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | REG_W | Destination of the writeback-stage instruction |
| wb_we | input | 1 | Writeback-stage instruction writes a register |
| alu_a_sel | output | 2 | 0 register, 1 PC+4, 2 Z |
| alu_b_sel | output | 2 | 0 register, 1 immediate, 2 Z |
| byp_a_sel | output | 2 | Operand A read source: 0 file, 1 memory stage, 2 writeback |
| byp_b_sel | output | 2 | Operand B read source: 0 file, 1 memory stage, 2 writeback |
| pc_hold | output | 1 | Keep the PC this cycle |
| fd_hold | output | 1 | Keep the fetch-to-decode buffer this cycle |
| de_bubble | output | 1 | Load a no-op into the decode-to-ALU buffer |

## Verification
The one-bubble check assumes that the surrounding pipeline obeys a stall. After a stall cycle, the load must have left the ALU stage and a non-writing bubble must have replaced it, so no two stall cycles occur back to back. The stimulus table follows this rule: every stall row is followed by the row a real pipeline would present next, with the load moved to the memory stage and write enable clear in the ALU stage. The other checks relate the outputs to the stage contents within one cycle and need no such assumption. During reset the inputs are held at zero.

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_use_rs1,
  input  logic             id_use_rs2,
  input  logic             id_a_is_pc,
  input  logic             id_b_is_imm,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic [1:0]       alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       byp_a_sel,
  output logic [1:0]       byp_b_sel,
  output logic             pc_hold,
  output logic             fd_hold,
  output logic             de_bubble
);

  localparam logic [1:0] SEL_REG = 2'd0;
  localparam logic [1:0] SEL_ALT = 2'd1;
  localparam logic [1:0] SEL_Z   = 2'd2;
  localparam logic [1:0] BYP_RF  = 2'd0;
  localparam logic [1:0] BYP_S4  = 2'd1;
  localparam logic [1:0] BYP_S5  = 2'd2;

  logic             ex_live, mem_live, wb_live;
  logic [REG_W-1:0] src    [2];
  logic             use_f  [2];
  logic             alt_f  [2];
  logic             hit_ex [2];
  logic [1:0]       alu_s  [2];
  logic [1:0]       byp_s  [2];
  logic             stall;

  assign ex_live  = ex_we  && (ex_rd  != '0);
  assign mem_live = mem_we && (mem_rd != '0);
  assign wb_live  = wb_we  && (wb_rd  != '0);

  assign src[0]   = id_rs1;
  assign src[1]   = id_rs2;
  assign use_f[0] = id_use_rs1;
  assign use_f[1] = id_use_rs2;
  assign alt_f[0] = id_a_is_pc;
  assign alt_f[1] = id_b_is_imm;

  for (genvar g = 0; g < 2; g++) begin : g_src
    logic hit_mem, hit_wb;
    assign hit_ex[g] = use_f[g] && ex_live  && (ex_rd  == src[g]);
    assign hit_mem   = use_f[g] && mem_live && (mem_rd == src[g]);
    assign hit_wb    = use_f[g] && wb_live  && (wb_rd  == src[g]);
    assign alu_s[g]  = alt_f[g]                    ? SEL_ALT :
                       (hit_ex[g] && !ex_is_load)  ? SEL_Z   : SEL_REG;
    assign byp_s[g]  = hit_mem ? BYP_S4 : hit_wb ? BYP_S5 : BYP_RF;
  end

  assign stall     = ex_is_load && (hit_ex[0] || hit_ex[1]);
  assign alu_a_sel = alu_s[0];
  assign alu_b_sel = alu_s[1];
  assign byp_a_sel = byp_s[0];
  assign byp_b_sel = byp_s[1];
  assign pc_hold   = stall;
  assign fd_hold   = stall;
  assign de_bubble = stall;

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    alu_a_sel != 2'd3 && alu_b_sel != 2'd3) else $error("sel"); // R1
  AST_BYP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    byp_a_sel != 2'd3 && byp_b_sel != 2'd3) else $error("byp"); // R3
  AST_STALL_TRIO: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold == fd_hold && fd_hold == de_bubble) else $error("trio"); // R9
  AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    de_bubble |=> !de_bubble) else $error("bubble"); // R6
  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == '0) |-> (byp_a_sel == BYP_RF && alu_a_sel != SEL_Z)) else $error("r0"); // R7
  AST_NO_WE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_we |-> (!pc_hold && alu_a_sel != SEL_Z && alu_b_sel != SEL_Z)) else $error("we"); // R8
  AST_LOAD_NO_Z: assert property (@(posedge clk) disable iff (!rst_n)
    ex_is_load |-> (alu_a_sel != SEL_Z && alu_b_sel != SEL_Z)) else $error("ldz"); // R5

endmodule

// File: tb/fwd_stall_unit_tb.sv
module fwd_stall_unit_tb;
  localparam int RW = 5;
  localparam int NV = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [RW-1:0] id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
  logic id_use_rs1, id_use_rs2, id_a_is_pc, id_b_is_imm;
  logic ex_we, ex_is_load, mem_we, wb_we;
  logic [1:0] alu_a_sel, alu_b_sel, byp_a_sel, byp_b_sel;
  logic pc_hold, fd_hold, de_bubble;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  fwd_stall_unit #(.REG_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .id_a_is_pc(id_a_is_pc), .id_b_is_imm(id_b_is_imm),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .byp_a_sel(byp_a_sel), .byp_b_sel(byp_b_sel),
    .pc_hold(pc_hold), .fd_hold(fd_hold), .de_bubble(de_bubble));

  // stim: apc bimm u1 u2 rs1 rs2 exrd exwe exld mrd mwe wrd wwe | exp: asel bsel b1 b2 stall
  localparam logic [41:0] VEC [NV] = '{
    {4'b0011, 5'd1, 5'd2, 5'd0, 2'b00, 5'd0, 1'b0, 5'd0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // R8 idle
    {4'b0011, 5'd1, 5'd2, 5'd1, 2'b10, 5'd0, 1'b0, 5'd0, 1'b0, 2'd2, 2'd0, 2'd0, 2'd0, 1'b0}, // R1 Z on A
    {4'b0011, 5'd1, 5'd2, 5'd2, 2'b10, 5'd0, 1'b0, 5'd0, 1'b0, 2'd0, 2'd2, 2'd0, 2'd0, 1'b0}, // R2 Z on B
    {4'b0111, 5'd1, 5'd2, 5'd2, 2'b10, 5'd0, 1'b0, 5'd0, 1'b0, 2'd0, 2'd1, 2'd0, 2'd0, 1'b0}, // R2 imm wins
    {4'b1011, 5'd1, 5'd2, 5'd1, 2'b10, 5'd0, 1'b0, 5'd0, 1'b0, 2'd1, 2'd0, 2'd0, 2'd0, 1'b0}, // R1 pc wins
    {4'b0011, 5'd1, 5'd2, 5'd0, 2'b00, 5'd1, 1'b1, 5'd0, 1'b0, 2'd0, 2'd0, 2'd1, 2'd0, 1'b0}, // R3 stage4
    {4'b0011, 5'd1, 5'd2, 5'd0, 2'b00, 5'd0, 1'b0, 5'd2, 1'b1, 2'd0, 2'd0, 2'd0, 2'd2, 1'b0}, // R3 stage5
    {4'b0011, 5'd1, 5'd2, 5'd0, 2'b00, 5'd1, 1'b1, 5'd1, 1'b1, 2'd0, 2'd0, 2'd1, 2'd0, 1'b0}, // R4 4 over 5
    {4'b0011, 5'd1, 5'd2, 5'd1, 2'b10, 5'd1, 1'b1, 5'd2, 1'b1, 2'd2, 2'd0, 2'd1, 2'd2, 1'b0}, // R4 newest
    {4'b0011, 5'd3, 5'd2, 5'd2, 2'b11, 5'd0, 1'b0, 5'd0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1}, // R5 load-use
    {4'b0011, 5'd3, 5'd2, 5'd0, 2'b00, 5'd2, 1'b1, 5'd0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd1, 1'b0}, // R6 after bubble
    {4'b0011, 5'd0, 5'd4, 5'd0, 2'b11, 5'd0, 1'b1, 5'd0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // R7 r0
    {4'b0011, 5'd0, 5'd0, 5'd0, 2'b10, 5'd0, 1'b1, 5'd0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // R7 r0 all
    {4'b0011, 5'd1, 5'd2, 5'd1, 2'b00, 5'd2, 1'b0, 5'd1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // R8 we clear
    {4'b0001, 5'd6, 5'd2, 5'd6, 2'b11, 5'd6, 1'b1, 5'd6, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // R8 unused src
    {4'b0011, 5'd6, 5'd7, 5'd5, 2'b11, 5'd0, 1'b0, 5'd0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}  // R5 other rd
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [41:0] v);
    {id_a_is_pc, id_b_is_imm, id_use_rs1, id_use_rs2, id_rs1, id_rs2,
     ex_rd, ex_we, ex_is_load, mem_rd, mem_we, wb_rd, wb_we} = v[41:9];
  endtask

  task automatic check_vec(input string tag, input logic [41:0] v);
    chk({tag, " alu_a_sel"}, alu_a_sel, v[8:7]);
    chk({tag, " alu_b_sel"}, alu_b_sel, v[6:5]);
    chk({tag, " byp_a_sel"}, byp_a_sel, v[4:3]);
    chk({tag, " byp_b_sel"}, byp_b_sel, v[2:1]);
    chk({tag, " pc_hold"},   pc_hold,   v[0]);
    chk({tag, " fd_hold R9"}, fd_hold,  v[0]);
    chk({tag, " de_bubble R9"}, de_bubble, v[0]);
  endtask

  initial begin
    apply('0);
    repeat (3) @(negedge clk);
    #2;
    chk("reset R8 pc_hold", pc_hold, 0);
    chk("reset R7 alu_a_sel", alu_a_sel, 0);
    chk("reset R7 byp_a_sel", byp_a_sel, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      #2;
      check_vec($sformatf("vec%0d", i), VEC[i]);
    end
    // R5 load hitting both sources, then R6 advance
    @(negedge clk);
    apply({4'b0011, 5'd9, 5'd9, 5'd9, 2'b11, 5'd0, 1'b0, 5'd0, 1'b0, 9'd0});
    #2;
    chk("R5 both sources stall", de_bubble, 1);
    chk("R5 both sources asel", alu_a_sel, 0);
    @(negedge clk);
    apply({4'b0011, 5'd9, 5'd9, 5'd0, 2'b00, 5'd9, 1'b1, 5'd0, 1'b0, 9'd0});
    #2;
    chk("R6 no second stall", pc_hold, 0);
    chk("R6 byp_a", byp_a_sel, 1);
    chk("R6 byp_b", byp_b_sel, 1);
    // R8 writeback with we clear
    @(negedge clk);
    apply({4'b0011, 5'd4, 5'd4, 5'd0, 2'b00, 5'd0, 1'b0, 5'd4, 1'b0, 9'd0});
    #2;
    chk("R8 wb we clear", byp_a_sel, 0);
    // R2 with PC on A and Z on B together
    @(negedge clk);
    apply({4'b1011, 5'd4, 5'd8, 5'd8, 2'b10, 5'd0, 1'b0, 5'd0, 1'b0, 9'd0});
    #2;
    chk("R1 pc", alu_a_sel, 1);
    chk("R2 z", alu_b_sel, 2);
    @(negedge clk);
    apply('0);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule